// File: doc/BRIEF.md
# Indexed configuration port controller

This block is the configuration front end of a multi-function legacy I/O controller. A host reaches it over a simple byte-wide I/O bus made of an address, a write strobe, a read strobe and byte data. Every access takes one cycle and the block never stalls the bus, so no back-pressure exists at this edge. A strap input chooses between two base addresses. The index port sits at the base and the data port at base plus one.

A key byte written to the index port opens configuration mode, and a second key byte closes it. While the mode is open, the index port selects a register and the data port reads or writes that register. A logical-device-number register, reached from every bank, picks which bank the data port reaches. Bank zero holds the global registers: configure control, power control, power management and oscillator control. Banks one to four each hold the register set of one device.

The block decodes these registers into plain control outputs. The outputs are per-function power enables, an oscillator enable, an automatic power-management enable, and for each device an activate bit, a 16-bit base address, an IRQ select and a mode byte.

Top module: `cfg_port_ctrl`

## Requirements
- R1: The index port is at 0x3F0 and the data port at 0x3F1 while `alt_base` is 0. When `alt_base` is 1 they move to 0x370 and 0x371. Accesses at any other address have no effect.
- R2: A write of 0x55 to the index port while the mode is closed opens configuration mode. The same byte written to any other address, including the data port, leaves the mode closed.
- R3: While the mode is open, a write of 0xAA to the index port closes the mode. Any other byte written to the index port loads the index register.
- R4: While the mode is closed, writes to either port change no register, and every read returns 0x00.
- R5: Index 0x07 is the logical device number (LDN). It is written and read as a full byte from any bank, and it selects the bank for every other index.
- R6: With LDN 0, indices 0x02, 0x22, 0x23 and 0x24 reach the global registers. With any other LDN those indices reach nothing. In the power register 0x22, bit 0 drives `pwr_en[0]` (floppy), bit 3 drives `pwr_en[1]` (parallel), bit 4 drives `pwr_en[2]` (serial 1) and bit 5 drives `pwr_en[3]` (serial 2). All other bits read 0.
- R7: Bit 2 of register 0x24 drives `osc_en`, and its other bits read 0. `auto_pm_en` is 1 exactly when register 0x23 is nonzero.
- R8: With LDN k in 1..4, the bank for device k-1 is reached. Bit 0 of index 0x30 drives `dev_active[k-1]`. Index 0x60 is the high byte and index 0x61 the low byte of `dev_base[16(k-1)+:16]`. Bits 3:0 of index 0x70 drive `dev_irq[4(k-1)+:4]`. Index 0xF0 drives `dev_mode[8(k-1)+:8]`. Unused bits read 0.
- R9: A write to an index that is undefined for the selected bank, or to any index while the LDN is above 4, changes nothing. A read there returns 0x00.
- R10: While the mode is open, reading the index port returns the current index. Reading the data port returns the selected register in the same cycle that `io_rd` is high.
- R11: Reset closes the mode and clears the index, the LDN and every register, so every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alt_base | input | 1 | Strap: 1 selects the alternate base 0x370 |
| io_addr | input | 16 | Host I/O address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational, 0 unless a valid read |
| pwr_en | output | 4 | Power enables {serial 2, serial 1, parallel, floppy} |
| osc_en | output | 1 | Oscillator and baud clock enable |
| auto_pm_en | output | 1 | Automatic power management enabled |
| dev_active | output | 4 | Device activate bits |
| dev_base | output | 64 | Per-device 16-bit base addresses |
| dev_irq | output | 16 | Per-device 4-bit IRQ selects |
| dev_mode | output | 32 | Per-device mode bytes |

## Verification
A wrong lock state shows up at the first read of the index port. A wrongly open mode returns a nonzero index, and a wrongly closed mode returns 0x00 where the index was expected. A wrong LDN or index shows up one cycle after the next data write, when a decoded output of the wrong bank or bit moves, or at once on a data read. All decoded outputs are compared against a behavioural model on every clock, so a stray register update is caught within one cycle.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam logic [7:0] KEY_ENTER = 8'h55;
  localparam logic [7:0] KEY_EXIT  = 8'hAA;

  localparam logic [7:0] IDX_CCTL  = 8'h02;
  localparam logic [7:0] IDX_LDN   = 8'h07;
  localparam logic [7:0] IDX_PWR   = 8'h22;
  localparam logic [7:0] IDX_PM    = 8'h23;
  localparam logic [7:0] IDX_OSC   = 8'h24;
  localparam logic [7:0] IDX_ACT   = 8'h30;
  localparam logic [7:0] IDX_BHI   = 8'h60;
  localparam logic [7:0] IDX_BLO   = 8'h61;
  localparam logic [7:0] IDX_IRQ   = 8'h70;
  localparam logic [7:0] IDX_MODE  = 8'hF0;

  localparam logic [7:0] PWR_MASK  = 8'h39;
  localparam logic [7:0] OSC_MASK  = 8'h04;
  localparam int         IRQ_BITS  = 4;

  typedef struct packed {
    logic                act;
    logic [7:0]          bhi;
    logic [7:0]          blo;
    logic [IRQ_BITS-1:0] irq;
    logic [7:0]          mode;
  } dev_regs_t;
endpackage

// File: rtl/cfg_key_unit.sv
module cfg_key_unit
  import cfg_port_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] BASE_PRI = 16'h03F0,
  parameter logic [ADDR_W-1:0] BASE_ALT = 16'h0370
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alt_base,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic [7:0]        io_wdata,
  output logic              cfg_open,
  output logic [7:0]        cfg_index,
  output logic              hit_idx,
  output logic              hit_dat,
  output logic              data_we
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] base;

  always_comb begin
    base    = alt_base ? BASE_ALT : BASE_PRI;
    hit_idx = (io_addr == base);
    hit_dat = (io_addr == base + ONE);
    data_we = io_wr && hit_dat && cfg_open;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_open  <= 1'b0;
      cfg_index <= '0;
    end else if (io_wr && hit_idx) begin
      if (!cfg_open) begin
        if (io_wdata == KEY_ENTER) cfg_open <= 1'b1;
      end else if (io_wdata == KEY_EXIT) begin
        cfg_open <= 1'b0;
      end else begin
        cfg_index <= io_wdata;
      end
    end
  end

  // R2
  key_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(io_wr && hit_idx && io_wdata == KEY_ENTER));
  // R3
  key_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_open) |-> $past(io_wr && hit_idx && io_wdata == KEY_EXIT));
  // R4
  closed_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |=> $stable(cfg_index));
endmodule

// File: rtl/cfg_global_regs.sv
module cfg_global_regs
  import cfg_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_open,
  input  logic       data_we,
  input  logic [7:0] cfg_index,
  input  logic [7:0] wdata,
  output logic [7:0] ldn,
  output logic [7:0] cctl,
  output logic [7:0] pwr,
  output logic [7:0] pm,
  output logic [7:0] osc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ldn  <= '0;
      cctl <= '0;
      pwr  <= '0;
      pm   <= '0;
      osc  <= '0;
    end else if (data_we) begin
      if (cfg_index == IDX_LDN) begin
        ldn <= wdata;
      end else if (ldn == 8'd0) begin
        case (cfg_index)
          IDX_CCTL: cctl <= wdata;
          IDX_PWR:  pwr  <= wdata & PWR_MASK;
          IDX_PM:   pm   <= wdata;
          IDX_OSC:  osc  <= wdata & OSC_MASK;
          default:  ;
        endcase
      end
    end
  end

  // R4
  locked_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |=> $stable({ldn, cctl, pwr, pm, osc}));
  // R5
  ldn_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(data_we && cfg_index == IDX_LDN) |-> $stable(ldn));
  // R6
  pwr_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr & ~PWR_MASK) == 8'd0);
  // R7
  osc_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (osc & ~OSC_MASK) == 8'd0);
endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank
  import cfg_port_pkg::*;
#(
  parameter int LDN_VAL = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       data_we,
  input  logic [7:0] cfg_index,
  input  logic [7:0] ldn,
  input  logic [7:0] wdata,
  output dev_regs_t  regs
);
  logic sel;

  always_comb sel = (ldn == 8'(LDN_VAL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs <= '0;
    end else if (data_we && sel) begin
      case (cfg_index)
        IDX_ACT:  regs.act  <= wdata[0];
        IDX_BHI:  regs.bhi  <= wdata;
        IDX_BLO:  regs.blo  <= wdata;
        IDX_IRQ:  regs.irq  <= wdata[IRQ_BITS-1:0];
        IDX_MODE: regs.mode <= wdata;
        default:  ;
      endcase
    end
  end

  // R9
  unsel_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(data_we && sel) |-> $stable(regs));
endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
  import cfg_port_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] BASE_PRI = 16'h03F0,
  parameter logic [ADDR_W-1:0] BASE_ALT = 16'h0370,
  parameter int                NUM_DEV  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       alt_base,
  input  logic [ADDR_W-1:0]          io_addr,
  input  logic                       io_wr,
  input  logic                       io_rd,
  input  logic [7:0]                 io_wdata,
  output logic [7:0]                 io_rdata,
  output logic [3:0]                 pwr_en,
  output logic                       osc_en,
  output logic                       auto_pm_en,
  output logic [NUM_DEV-1:0]         dev_active,
  output logic [NUM_DEV*16-1:0]      dev_base,
  output logic [NUM_DEV*IRQ_BITS-1:0] dev_irq,
  output logic [NUM_DEV*8-1:0]       dev_mode
);
  logic       cfg_open, hit_idx, hit_dat, data_we;
  logic [7:0] cfg_index, ldn, cctl, pwr, pm, osc;
  dev_regs_t  bank_q [NUM_DEV];

  cfg_key_unit #(.ADDR_W(ADDR_W), .BASE_PRI(BASE_PRI), .BASE_ALT(BASE_ALT)) i_key (
    .clk(clk), .rst_n(rst_n), .alt_base(alt_base), .io_addr(io_addr),
    .io_wr(io_wr), .io_wdata(io_wdata), .cfg_open(cfg_open),
    .cfg_index(cfg_index), .hit_idx(hit_idx), .hit_dat(hit_dat),
    .data_we(data_we)
  );

  cfg_global_regs i_glob (
    .clk(clk), .rst_n(rst_n), .cfg_open(cfg_open), .data_we(data_we),
    .cfg_index(cfg_index), .wdata(io_wdata), .ldn(ldn), .cctl(cctl),
    .pwr(pwr), .pm(pm), .osc(osc)
  );

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_bank
    cfg_dev_bank #(.LDN_VAL(g + 1)) i_bank (
      .clk(clk), .rst_n(rst_n), .data_we(data_we), .cfg_index(cfg_index),
      .ldn(ldn), .wdata(io_wdata), .regs(bank_q[g])
    );
    assign dev_active[g]                       = bank_q[g].act;
    assign dev_base[g*16 +: 16]                = {bank_q[g].bhi, bank_q[g].blo};
    assign dev_irq[g*IRQ_BITS +: IRQ_BITS]     = bank_q[g].irq;
    assign dev_mode[g*8 +: 8]                  = bank_q[g].mode;
  end

  assign pwr_en     = {pwr[5], pwr[4], pwr[3], pwr[0]};
  assign osc_en     = osc[2];
  assign auto_pm_en = |pm;

  always_comb begin
    io_rdata = '0;
    if (io_rd && cfg_open) begin
      if (hit_idx) begin
        io_rdata = cfg_index;
      end else if (hit_dat) begin
        if (cfg_index == IDX_LDN) begin
          io_rdata = ldn;
        end else if (ldn == 8'd0) begin
          case (cfg_index)
            IDX_CCTL: io_rdata = cctl;
            IDX_PWR:  io_rdata = pwr;
            IDX_PM:   io_rdata = pm;
            IDX_OSC:  io_rdata = osc;
            default:  io_rdata = '0;
          endcase
        end else begin
          for (int k = 0; k < NUM_DEV; k++) begin
            if (ldn == 8'(k + 1)) begin
              case (cfg_index)
                IDX_ACT:  io_rdata = {7'd0, bank_q[k].act};
                IDX_BHI:  io_rdata = bank_q[k].bhi;
                IDX_BLO:  io_rdata = bank_q[k].blo;
                IDX_IRQ:  io_rdata = 8'(bank_q[k].irq);
                IDX_MODE: io_rdata = bank_q[k].mode;
                default:  io_rdata = '0;
              endcase
            end
          end
        end
      end
    end
  end

  // R4
  closed_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |-> io_rdata == 8'd0);
  // R7
  pm_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_pm_en == (pm != 8'd0));
endmodule

// File: tb/test_cfg_port_ctrl.sv
module test_cfg_port_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alt_base = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic [3:0]  pwr_en;
  logic        osc_en, auto_pm_en;
  logic [3:0]  dev_active;
  logic [63:0] dev_base;
  logic [15:0] dev_irq;
  logic [31:0] dev_mode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference model
  bit m_open;
  int m_index, m_ldn;
  int mem [0:4][0:255];

  always #5 clk = ~clk;

  cfg_port_ctrl i_cfg_port_ctrl (
    .clk(clk), .rst_n(rst_n), .alt_base(alt_base), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .pwr_en(pwr_en), .osc_en(osc_en), .auto_pm_en(auto_pm_en),
    .dev_active(dev_active), .dev_base(dev_base), .dev_irq(dev_irq),
    .dev_mode(dev_mode)
  );

  function automatic int base_of();
    return alt_base ? 32'h370 : 32'h3F0;
  endfunction

  function automatic int wmask(int b, int i);
    if (i == 8'h07) return 8'hFF;
    if (b == 0) begin
      if (i == 8'h02 || i == 8'h23) return 8'hFF;
      if (i == 8'h22) return 8'h39;
      if (i == 8'h24) return 8'h04;
      return 0;
    end
    if (b >= 1 && b <= 4) begin
      if (i == 8'h30) return 8'h01;
      if (i == 8'h60 || i == 8'h61 || i == 8'hF0) return 8'hFF;
      if (i == 8'h70) return 8'h0F;
    end
    return 0;
  endfunction

  task automatic model_reset();
    m_open = 0; m_index = 0; m_ldn = 0;
    for (int b = 0; b < 5; b++)
      for (int i = 0; i < 256; i++) mem[b][i] = 0;
  endtask

  task automatic model_write(int a, int d);
    if (a == base_of()) begin
      if (!m_open) begin
        if (d == 8'h55) m_open = 1;
      end else if (d == 8'hAA) m_open = 0;
      else m_index = d;
    end else if (a == base_of() + 1 && m_open) begin
      if (m_index == 8'h07) m_ldn = d;
      else if (wmask(m_ldn, m_index) != 0) mem[m_ldn][m_index] = d & wmask(m_ldn, m_index);
    end
  endtask

  function automatic int model_read(int a);
    if (!m_open) return 0;
    if (a == base_of()) return m_index;
    if (a == base_of() + 1) begin
      if (m_index == 8'h07) return m_ldn;
      if (wmask(m_ldn, m_index) != 0) return mem[m_ldn][m_index];
    end
    return 0;
  endfunction

  function automatic logic [121:0] model_outs();
    logic [121:0] v;
    logic [3:0] pe;
    pe = {mem[0][8'h22][5], mem[0][8'h22][4], mem[0][8'h22][3], mem[0][8'h22][0]};
    v = '0;
    v[121:118] = pe;
    v[117] = mem[0][8'h24][2];
    v[116] = (mem[0][8'h23] != 0);
    for (int k = 0; k < 4; k++) begin
      v[112+k] = mem[k+1][8'h30][0];
      v[48+k*16 +: 16] = {mem[k+1][8'h60][7:0], mem[k+1][8'h61][7:0]};
      v[32+k*4 +: 4] = mem[k+1][8'h70][3:0];
      v[k*8 +: 8] = mem[k+1][8'hF0][7:0];
    end
    return v;
  endfunction

  function automatic logic [121:0] dut_outs();
    return {pwr_en, osc_en, auto_pm_en, dev_active, dev_base, dev_irq, dev_mode};
  endfunction

  task automatic chk(string tag, longint got, longint exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // compare every clock against the model (R6, R7, R8 outputs)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (dut_outs() !== model_outs()) begin
        errors++;
        $display("FAIL R8 decoded outputs: got %h expected %h", dut_outs(), model_outs());
      end
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    io_addr = 16'(a); io_wdata = 8'(d); io_wr = 1'b1;
    @(posedge clk);
    model_write(a, d);
    #1 io_wr = 1'b0;
  endtask

  task automatic rd(int a, string tag);
    @(negedge clk);
    io_addr = 16'(a); io_rd = 1'b1;
    #2 chk(tag, io_rdata, model_read(a));
    io_rd = 1'b0;
  endtask

  task automatic reg_wr(int idx, int d);
    wr(base_of(), idx);
    wr(base_of() + 1, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired, all requirements");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R11 reset state
    @(negedge clk);
    chk("R11 outputs after reset", dut_outs(), 0);
    rd(16'h3F0, "R11 closed after reset");

    // R4 locked writes are ignored
    wr(16'h3F0, 8'h22);
    wr(16'h3F1, 8'h39);
    @(negedge clk) chk("R4 pwr_en locked", pwr_en, 0);
    rd(16'h3F1, "R4 locked data read");
    // R2 key at data port / R1 key at wrong base
    wr(16'h3F1, 8'h55);
    wr(16'h370, 8'h55);
    wr(16'h3F0, 8'h22);
    rd(16'h3F0, "R2 key elsewhere stays closed");
    chk("R2 index read zero", io_rdata, 0);

    // R2 unlock, R3 index load
    wr(16'h3F0, 8'h55);
    wr(16'h3F0, 8'h22);
    rd(16'h3F0, "R10 index readback");
    chk("R3 index loaded", model_read(16'h3F0), 8'h22);

    // R6 global registers via LDN 0
    reg_wr(8'h22, 8'hFF);
    @(negedge clk) chk("R6 pwr_en all", pwr_en, 4'hF);
    rd(16'h3F1, "R6 pwr readback masked");
    reg_wr(8'h22, 8'h11);
    @(negedge clk) chk("R6 pwr_en floppy+serial1", pwr_en, 4'b0101);
    reg_wr(8'h24, 8'hFF);
    @(negedge clk) chk("R7 osc_en", osc_en, 1);
    rd(16'h3F1, "R7 osc readback masked");
    reg_wr(8'h23, 8'h01);
    @(negedge clk) chk("R7 auto_pm on", auto_pm_en, 1);
    reg_wr(8'h23, 8'h00);
    @(negedge clk) chk("R7 auto_pm off", auto_pm_en, 0);
    reg_wr(8'h02, 8'h5A);
    rd(16'h3F1, "R6 configure control readback");

    // R8 device banks, R5 LDN select
    for (int k = 1; k <= 4; k++) begin
      reg_wr(8'h07, k);
      rd(16'h3F1, "R5 ldn readback");
      reg_wr(8'h30, 8'hFF);
      reg_wr(8'h60, 8'h10 * k);
      reg_wr(8'h61, 8'hF8 - k);
      reg_wr(8'h70, 8'hF0 + k + 2);
      rd(16'h3F1, "R8 irq readback masked");
      reg_wr(8'hF0, 8'hA0 + k);
      rd(16'h3F1, "R10 mode readback");
    end
    @(negedge clk);
    chk("R8 dev_active", dev_active, 4'hF);
    chk("R8 dev_base dev0", dev_base[15:0], 16'h10F7);
    chk("R8 dev_irq dev3", dev_irq[15:12], 4'h6);

    // R6 global index in a device bank reaches nothing
    reg_wr(8'h07, 2);
    reg_wr(8'h22, 8'h00);
    @(negedge clk) chk("R6 pwr_en untouched from bank 2", pwr_en, 4'b0101);
    // R9 undefined index and undefined bank
    reg_wr(8'h31, 8'h77);
    rd(16'h3F1, "R9 undefined index read");
    reg_wr(8'h07, 9);
    reg_wr(8'h30, 8'h00);
    rd(16'h3F1, "R9 undefined bank read");
    @(negedge clk) chk("R9 dev_active untouched", dev_active, 4'hF);
    // deactivate device 2
    reg_wr(8'h07, 2);
    reg_wr(8'h30, 8'h00);
    @(negedge clk) chk("R8 dev_active cleared", dev_active, 4'b1101);

    // R3 lock, R4 writes after lock ignored
    wr(16'h3F0, 8'hAA);
    wr(16'h3F1, 8'h01);
    rd(16'h3F0, "R3 closed after exit key");
    @(negedge clk) chk("R4 dev_active after lock", dev_active, 4'b1101);

    // R1 alternate base
    @(negedge clk) alt_base = 1'b1;
    wr(16'h3F0, 8'h55);
    rd(16'h370, "R1 old base ignored");
    wr(16'h370, 8'h55);
    wr(16'h370, 8'h07);
    wr(16'h371, 8'h03);
    wr(16'h370, 8'hF0);
    wr(16'h371, 8'h3C);
    rd(16'h371, "R1 alternate data port");
    @(negedge clk) chk("R1 mode via alt base", dev_mode[23:16], 8'h3C);
    wr(16'h3F1, 8'h00);
    @(negedge clk) chk("R1 old data port ignored", dev_mode[23:16], 8'h3C);

    // R11 reset mid-run
    @(negedge clk) rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    chk("R11 outputs cleared", dut_outs(), 0);
    @(negedge clk) rst_n = 1'b1;
    rd(16'h370, "R11 closed after reset");

    repeat (2) @(negedge clk);
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule